// File: doc/BRIEF.md
# Timed Level-Sequence Trigger

This block watches one digital line, for example the data wire of a serial link, and raises a trigger when the line shows a programmed series of levels. Each level must stay put for a number of clock cycles inside its own window, given as a minimum and a maximum hold count. A pattern has between one and `STEPS` steps. Each step is loaded through a small write port that carries a step index, an expected level, a minimum count and a maximum count. A separate input selects the index of the final step.

The line is asynchronous to the block clock, so it passes through a two-flop synchroniser first. A state machine with one state per step then follows the synchronised samples. It moves to the next step only when the line changes level after a hold that falls inside the window. Any other behaviour sends it back to the start, and the same sample is then tested as a possible start of step 0. When the final step completes, `trig` pulses for one cycle. The same pulse also goes to `trig_pin`, an output that carries it only while `route_en` is set.

Top module: `pattern_trigger`

## Requirements
- R1: The line passes through two synchronising flops. If the sample captured at rising edge k completes the pattern, `trig` is high after edge k+2 and for that cycle only.
- R2: Steps run in order from 0 to `last_step`. Step j is satisfied when the line sits at its level (`cfg_level` 1 = high) for a count of consecutive samples n with min <= n <= max. The machine then moves to step j+1 on the first sample at a different level, and that sample must equal the level of step j+1.
- R3: If the line leaves a step's level after fewer samples than that step's minimum, the machine restarts.
- R4: If the line stays at a step's level for more samples than that step's maximum, the machine restarts. A sample that causes any restart is tested as the first sample of step 0 in the same cycle.
- R5: The final step completes as soon as its held count reaches its minimum. The line does not have to leave the final level.
- R6: Each completion gives exactly one one-cycle `trig` pulse. The machine then returns to idle, and the next sample is tested afresh against step 0. With a one-step pattern, a steady matching level therefore fires once every min samples.
- R7: `trig_pin` pulses in the same cycle as `trig` when `route_en` was high at the completing edge. Otherwise it stays low.
- R8: A write with `cfg_we` high stores level, minimum and maximum into step `cfg_idx`. Patterns of any length from 1 to `STEPS` steps are matched, as selected by `last_step`.
- R9: While `rst_n` is low, `trig` and `trig_pin` are low and the matcher is idle. Reset also clears any partly matched pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Watched digital line, asynchronous |
| cfg_we | input | 1 | Step write strobe |
| cfg_idx | input | 3 | Step index to write |
| cfg_level | input | 1 | Expected level for the step (1 = high) |
| cfg_min | input | 16 | Minimum hold count in samples |
| cfg_max | input | 16 | Maximum hold count in samples |
| last_step | input | 3 | Index of the final step of the pattern |
| route_en | input | 1 | Enables the trigger onto `trig_pin` |
| trig | output | 1 | One-cycle match pulse |
| trig_pin | output | 1 | Routed copy of the match pulse |

## Verification
If the step index or hold counter goes wrong, the block either fires when it should not or misses a pulse. Either way the error shows at `trig` no later than the end of the pattern. The bench checks both the pulse count and the exact cycle of each pulse, so a counter that is off by one moves the pulse and is caught. Restart errors are probed with two cases. In one, the line overstays step 0 by exactly enough that only a same-cycle restart can still complete the pattern. In the other, the line overstays by too much for any restart to complete it.

// File: rtl/pattern_trigger_pkg.sv
package pattern_trigger_pkg;

    // Matcher phase: waiting for step 0, or following a step.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_TRACK = 1'b1
    } phase_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pt_sync.sv
module pt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pt_step_store.sv
module pt_step_store #(
    parameter int unsigned STEPS = 8,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned IDX_W = pattern_trigger_pkg::idx_width(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             lvl_i,
    input  logic [CNT_W-1:0] min_i,
    input  logic [CNT_W-1:0] max_i,
    output logic             lvl_o [STEPS],
    output logic [CNT_W-1:0] min_o [STEPS],
    output logic [CNT_W-1:0] max_o [STEPS]
);

    generate
        for (genvar g = 0; g < STEPS; g++) begin : g_slot
            logic             lvl_q;
            logic [CNT_W-1:0] min_q;
            logic [CNT_W-1:0] max_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_q <= 1'b0;
                    min_q <= CNT_W'(1);
                    max_q <= '1;
                end else if (we_i && (idx_i == IDX_W'(g))) begin
                    lvl_q <= lvl_i;
                    min_q <= min_i;
                    max_q <= max_i;
                end
            end

            assign lvl_o[g] = lvl_q;
            assign min_o[g] = min_q;
            assign max_o[g] = max_q;
        end
    endgenerate

endmodule

// File: rtl/pt_matcher.sv
module pt_matcher
    import pattern_trigger_pkg::*;
#(
    parameter int unsigned STEPS = 8,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned IDX_W = idx_width(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_i,
    input  logic             lvl_i [STEPS],
    input  logic [CNT_W-1:0] min_i [STEPS],
    input  logic [CNT_W-1:0] max_i [STEPS],
    input  logic [IDX_W-1:0] last_i,
    input  logic             route_i,
    output logic             fire_o,
    output logic             pin_o,
    output logic             trk_o,
    output logic [IDX_W-1:0] step_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cur_max_o
);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] step;
        logic [CNT_W-1:0] cnt;
        logic             fire;
        logic             pin;
    } mstate_t;

    mstate_t st_d, st_q;

    logic             cur_lvl;
    logic [CNT_W-1:0] cur_min;
    logic [CNT_W-1:0] cur_max;
    logic [IDX_W-1:0] nxt_idx;
    logic             tracking;
    logic             go_trk;
    logic [IDX_W-1:0] go_step;
    logic [CNT_W-1:0] go_cnt;
    logic             done;

    always_comb begin
        cur_lvl  = lvl_i[st_q.step];
        cur_min  = min_i[st_q.step];
        cur_max  = max_i[st_q.step];
        nxt_idx  = st_q.step + 1'b1;
        tracking = (st_q.phase == PH_TRACK);

        go_trk  = 1'b0;
        go_step = '0;
        go_cnt  = '0;

        if (tracking && (smp_i == cur_lvl) && (st_q.cnt < cur_max)) begin
            // still holding the level, inside the window
            go_trk  = 1'b1;
            go_step = st_q.step;
            go_cnt  = st_q.cnt + 1'b1;
        end else if (tracking && (smp_i != cur_lvl) && (st_q.cnt >= cur_min)
                     && (st_q.step != last_i) && (smp_i == lvl_i[nxt_idx])) begin
            // legal level change into the next step
            go_trk  = 1'b1;
            go_step = nxt_idx;
            go_cnt  = CNT_W'(1);
        end else if (smp_i == lvl_i[0]) begin
            // idle, or restart: this sample may open step 0
            go_trk  = 1'b1;
            go_step = '0;
            go_cnt  = CNT_W'(1);
        end

        done = go_trk && (go_step == last_i) && (go_cnt >= min_i[go_step]);

        st_d.phase = (go_trk && !done) ? PH_TRACK : PH_IDLE;
        st_d.step  = done ? '0 : go_step;
        st_d.cnt   = done ? '0 : go_cnt;
        st_d.fire  = done;
        st_d.pin   = done && route_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, step: '0, cnt: '0, fire: 1'b0, pin: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o    = st_q.fire;
    assign pin_o     = st_q.pin;
    assign trk_o     = tracking;
    assign step_o    = st_q.step;
    assign cnt_o     = st_q.cnt;
    assign cur_max_o = cur_max;

endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger #(
    parameter int unsigned STEPS = 8,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W = pattern_trigger_pkg::idx_width(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_level,
    input  logic [CNT_W-1:0] cfg_min,
    input  logic [CNT_W-1:0] cfg_max,
    input  logic [IDX_W-1:0] last_step,
    input  logic             route_en,
    output logic             trig,
    output logic             trig_pin
);

    logic             line_s;
    logic             st_lvl [STEPS];
    logic [CNT_W-1:0] st_min [STEPS];
    logic [CNT_W-1:0] st_max [STEPS];
    logic             dbg_trk;
    logic [IDX_W-1:0] dbg_step;
    logic [CNT_W-1:0] dbg_cnt;
    logic [CNT_W-1:0] dbg_max;

    pt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_in),
        .q_o   (line_s)
    );

    pt_step_store #(.STEPS(STEPS), .CNT_W(CNT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (cfg_we),
        .idx_i (cfg_idx),
        .lvl_i (cfg_level),
        .min_i (cfg_min),
        .max_i (cfg_max),
        .lvl_o (st_lvl),
        .min_o (st_min),
        .max_o (st_max)
    );

    pt_matcher #(.STEPS(STEPS), .CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_i     (line_s),
        .lvl_i     (st_lvl),
        .min_i     (st_min),
        .max_i     (st_max),
        .last_i    (last_step),
        .route_i   (route_en),
        .fire_o    (trig),
        .pin_o     (trig_pin),
        .trk_o     (dbg_trk),
        .step_o    (dbg_step),
        .cnt_o     (dbg_cnt),
        .cur_max_o (dbg_max)
    );

endmodule

// File: rtl/pattern_trigger_chk.sv
module pattern_trigger_chk #(
    parameter int unsigned STEPS = 8,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned IDX_W = pattern_trigger_pkg::idx_width(STEPS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             trig_pin,
    input logic             route_en,
    input logic [IDX_W-1:0] last_step,
    input logic             dbg_trk,
    input logic [IDX_W-1:0] dbg_step,
    input logic [CNT_W-1:0] dbg_cnt,
    input logic [CNT_W-1:0] dbg_max
);

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_trk && $past(dbg_trk) && (dbg_step != $past(dbg_step)))
        |-> ((dbg_step == $past(dbg_step) + 1'b1) || (dbg_step == '0))); // R2

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trk |-> ((dbg_cnt >= CNT_W'(1)) && (dbg_cnt <= dbg_max))); // R4

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (last_step != '0)) |=> !trig); // R6

    AST_PIN_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig || trig_pin) |-> (trig_pin == (trig && $past(route_en)))); // R7

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trk |-> (dbg_step <= last_step)); // R8

endmodule

bind pattern_trigger pattern_trigger_chk #(.STEPS(STEPS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .trig_pin  (trig_pin),
    .route_en  (route_en),
    .last_step (last_step),
    .dbg_trk   (dbg_trk),
    .dbg_step  (dbg_step),
    .dbg_cnt   (dbg_cnt),
    .dbg_max   (dbg_max)
);

// File: tb/tb_pattern_trigger.sv
`timescale 1ns/1ps
module tb_pattern_trigger;

    localparam int unsigned STEPS = 8;
    localparam int unsigned CNT_W = 16;
    localparam int unsigned IDX_W = 3;
    localparam int NCASE = 9;

    // pattern 0-low[3..5], 1-high[2..4], 0-low[2..]; columns: a, b, c, pulses, tag
    localparam int CASES [NCASE][5] = '{
        '{4, 3, 3, 1, 2},
        '{3, 2, 2, 1, 2},
        '{5, 4, 2, 1, 5},
        '{8, 3, 3, 1, 4},
        '{2, 3, 3, 0, 3},
        '{6, 3, 3, 0, 4},
        '{3, 1, 3, 0, 3},
        '{3, 5, 3, 0, 4},
        '{4, 3, 1, 0, 3}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_in = 1'b1;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic             cfg_level = 1'b0;
    logic [CNT_W-1:0] cfg_min = '0;
    logic [CNT_W-1:0] cfg_max = '0;
    logic [IDX_W-1:0] last_step = 3'd2;
    logic             route_en = 1'b1;
    logic             trig;
    logic             trig_pin;

    int n_checks = 0;
    int n_fails = 0;
    int it = 0;
    int n_trig = 0;
    int n_pin = 0;
    int first_seen = -1;

    pattern_trigger #(.STEPS(STEPS), .CNT_W(CNT_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_level (cfg_level),
        .cfg_min   (cfg_min),
        .cfg_max   (cfg_max),
        .last_step (last_step),
        .route_en  (route_en),
        .trig      (trig),
        .trig_pin  (trig_pin)
    );

    always #5 clk = ~clk;

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        it = 0; n_trig = 0; n_pin = 0; first_seen = -1;
    endtask

    // observe the outputs, then drive the next line sample
    task automatic step_line(input logic lv);
        @(negedge clk);
        if (trig) begin
            n_trig++;
            if (first_seen < 0) first_seen = it;
        end
        if (trig_pin) n_pin++;
        line_in = lv;
        it++;
    endtask

    task automatic hold(input logic lv, input int n);
        for (int i = 0; i < n; i++) step_line(lv);
    endtask

    task automatic write_step(input int idx, input logic lv, input int mn, input int mx);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_level = lv;
        cfg_min = CNT_W'(mn); cfg_max = CNT_W'(mx);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_main();
        write_step(0, 1'b0, 3, 5);
        write_step(1, 1'b1, 2, 4);
        write_step(2, 1'b0, 2, 6);
        last_step = 3'd2;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R9: outputs quiet in reset
        repeat (3) @(negedge clk);
        check(trig == 1'b0, "R9 trig in reset", int'(trig), 0);
        check(trig_pin == 1'b0, "R9 trig_pin in reset", int'(trig_pin), 0);
        rst_n = 1'b1;
        hold(1'b1, 6);
        load_main();                                   // R8 writes
        hold(1'b1, 10);

        // table walk: R2 R3 R4 R5 and R1 latency
        for (int k = 0; k < NCASE; k++) begin
            hold(1'b1, 6);
            clear_obs();
            hold(1'b0, CASES[k][0]);
            hold(1'b1, CASES[k][1]);
            hold(1'b0, CASES[k][2]);
            hold(1'b1, 20);
            check(n_trig == CASES[k][3], tag_name(CASES[k][4]), n_trig, CASES[k][3]);
            check(n_pin == CASES[k][3], "R7 routed copy", n_pin, CASES[k][3]);
            if (CASES[k][3] == 1) begin
                // firing sample is the 2nd of the final segment; two sync flops plus one state flop
                check(first_seen == CASES[k][0] + CASES[k][1] + 4, "R1 R5 pulse cycle",
                      first_seen, CASES[k][0] + CASES[k][1] + 4);
            end
        end

        // R7: routing disabled keeps the pin low while trig still fires
        route_en = 1'b0;
        hold(1'b1, 6);
        clear_obs();
        hold(1'b0, 4); hold(1'b1, 3); hold(1'b0, 3); hold(1'b1, 20);
        check(n_trig == 1, "R7 trig with routing off", n_trig, 1);
        check(n_pin == 0, "R7 pin gated off", n_pin, 0);
        route_en = 1'b1;

        // R9: reset in mid-pattern discards the partial match
        hold(1'b1, 6);
        clear_obs();
        hold(1'b0, 4); hold(1'b1, 3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        hold(1'b0, 3); hold(1'b1, 20);
        check(n_trig == 0, "R9 reset clears partial match", n_trig, 0);

        // R6: one-step pattern rearms and fires every min samples
        hold(1'b1, 6);
        write_step(0, 1'b0, 3, 9);
        last_step = 3'd0;
        clear_obs();
        hold(1'b1, 10);
        check(n_trig == 0, "R6 no fire on other level", n_trig, 0);
        clear_obs();
        hold(1'b0, 7); hold(1'b1, 10);
        check(n_trig == 2, "R6 repeat after rearm", n_trig, 2);
        check(first_seen == 5, "R6 first pulse cycle", first_seen, 5);

        // R8: full-depth pattern of alternating single samples
        for (int s = 0; s < 8; s++) write_step(s, logic'(s % 2), 1, 2);
        last_step = 3'd7;
        hold(1'b1, 6);
        clear_obs();
        for (int s = 0; s < 8; s++) step_line(logic'(s % 2));
        hold(1'b1, 15);
        check(n_trig == 1, "R8 eight-step match", n_trig, 1);
        check(first_seen == 10, "R8 eight-step pulse cycle", first_seen, 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule